// File: doc/BRIEF.md
# Tri-Level Line Sample Validator

This block qualifies data bits on a bipolar return-to-zero serial line. Its inputs are two comparator outputs: one reports a high level and the other reports a low level. When neither is asserted the line is at its null level. On each sample point the three levels are shifted into three ten-stage history registers. A data bit is declared only when the history has the right shape: a run of at least three identical high (or low) samples, then at least three null samples. The distance from the previous bit must also fall within a fixed window of samples. When a bit passes, a single-clock strobe is raised together with the bit's value. When the shape or the spacing is wrong, the word in progress is dropped and an error flag is raised. The flag stays up until the line has been idle long enough to re-arm the block.

The block runs from a 1 MHz reference clock. A speed select picks the sample rate: one sample per clock for the fast line, or one per eight clocks for the slow line. The same sample-count window therefore accepts roughly 83 to 125 kbit/s in fast mode and roughly 10.4 to 15.6 kbit/s in slow mode. Downstream word assembly consumes the strobe.

Control is a three-state machine that moves only on sample points. `S_IDLE` waits for the first bit of a word. The first qualified bit is accepted without a spacing test and moves to `S_WORD`. In `S_WORD` a bit whose spacing is inside the window is accepted. A bit outside the window moves to `S_ABORT`. A word gap (a full null history with the spacing count past the window) returns to `S_IDLE`. In `S_ABORT` bits are ignored, and a full null history returns to `S_IDLE`. From any state, an invalid sample or a direct swing between opposite levels moves to `S_ABORT`.

Top module: `trilevel_validator`

## Requirements
- R1: With `speed_low`=0 one sample is taken per clock. With `speed_low`=1 one sample is taken per 8 clocks, so a high level lasting only 5 clocks followed by null produces no strobe and no error in slow mode.
- R2: A high or low level counts only after three consecutive identical samples. A run of two high samples followed by nulls produces no strobe.
- R3: A run of at least three high (low) samples followed by three null samples yields a strobe with `bit_value`=1 (0). A high run followed by only two nulls and then another level yields no strobe for that pulse. In fast mode the strobe is high during the second clock after the edge that captures the third null.
- R4: Spacing is counted in samples between the points where successive bits qualify. Within a word a bit with spacing 8 to 12 inclusive is accepted. A bit with spacing 7, or with spacing 13 to 18, raises `err` and is not strobed.
- R5: A sample with both comparator inputs high raises `err` two clocks after the edge that takes it and clears the sample histories.
- R6: `bit_valid` lasts exactly one clock, and `bit_value` changes only in a clock where `bit_valid` is high.
- R7: A high sample taken directly after a low sample, or a low sample directly after a high sample, raises `err`.
- R8: While `err` is high no strobe is produced. `err` falls once ten consecutive null samples are seen, and the next qualified bit is accepted as the first bit of a word.
- R9: Inside a word, ten consecutive null samples with the spacing count above 12 end the word without error. The next qualified bit is then accepted as a first bit regardless of its spacing.
- R10: While `rst_n` is low, `bit_valid`, `bit_value` and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 1 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| speed_low | input | 1 | 1 selects the slow line (one sample per 8 clocks) |
| one_det | input | 1 | Comparator output: line at high level |
| zero_det | input | 1 | Comparator output: line at low level |
| bit_valid | output | 1 | Single-clock strobe for a qualified bit |
| bit_value | output | 1 | Value of the last qualified bit |
| err | output | 1 | Shape, rate or invalid-sample error, held until re-armed |

## Verification
Four properties are checked on every cycle. The strobe lasts one clock. The bit value moves only with a strobe. No strobe appears while the error flag is up. An invalid sample or an opposite-level swing raises the flag two clocks later. The bench scenarios cover the behaviour that depends on a history of samples: the 8 and 12 spacing boundaries against 7 and 13, word-gap re-arming after an abort, word end followed by a fresh first bit, rejection of short runs and missing nulls, and the slow-mode sample rate.

// File: rtl/trilevel_pkg.sv
package trilevel_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_WORD  = 2'd1,
        S_ABORT = 2'd2
    } vld_state_e;

    // lane order inside the sample history array
    localparam int LANE_HI   = 0;
    localparam int LANE_LO   = 1;
    localparam int LANE_NULL = 2;
    localparam int LANES     = 3;

endpackage

// File: rtl/trilevel_sampler.sv
module trilevel_sampler #(
    parameter int HIST_LEN = 10,
    parameter int DIV_LOW  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                speed_low,
    input  logic                one_det,
    input  logic                zero_det,
    output logic                samp_en,
    output logic                samp_d,
    output logic                bad_q,
    output logic [HIST_LEN-1:0] hi_hist,
    output logic [HIST_LEN-1:0] lo_hist,
    output logic [HIST_LEN-1:0] null_hist
);
    import trilevel_pkg::*;

    localparam int PRE_W = (DIV_LOW > 2) ? $clog2(DIV_LOW) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DIV_LOW - 1);

    logic [PRE_W-1:0]    pre_q;
    logic [LANES-1:0]    lane_in;
    logic [HIST_LEN-1:0] hist_q [LANES];
    logic                invalid, swing;

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
    end

    assign samp_en = speed_low ? (pre_q == PRE_LAST) : 1'b1;

    assign lane_in[LANE_HI]   = one_det & ~zero_det;
    assign lane_in[LANE_LO]   = zero_det & ~one_det;
    assign lane_in[LANE_NULL] = ~one_det & ~zero_det;

    assign invalid = one_det & zero_det;
    assign swing   = (lane_in[LANE_HI] & hist_q[LANE_LO][0]) |
                     (lane_in[LANE_LO] & hist_q[LANE_HI][0]);

    // newest sample enters stage 0, oldest sits at the top stage
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n || (samp_en && invalid))
                hist_q[g] <= '0;
            else if (samp_en)
                hist_q[g] <= {hist_q[g][HIST_LEN-2:0], lane_in[g]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_d <= 1'b0;
            bad_q  <= 1'b0;
        end else begin
            samp_d <= samp_en;
            bad_q  <= samp_en & (invalid | swing);
        end
    end

    assign hi_hist   = hist_q[LANE_HI];
    assign lo_hist   = hist_q[LANE_LO];
    assign null_hist = hist_q[LANE_NULL];

endmodule

// File: rtl/trilevel_shape.sv
module trilevel_shape #(
    parameter int HIST_LEN = 10,
    parameter int RUN      = 3
) (
    input  logic [HIST_LEN-1:0] hi_hist,
    input  logic [HIST_LEN-1:0] lo_hist,
    input  logic [HIST_LEN-1:0] null_hist,
    output logic                evt_hi,
    output logic                evt_lo,
    output logic                gap_full
);
    localparam int WIN = 2 * RUN;

    logic null_tail;

    // older RUN stages hold the level, newer RUN stages hold nulls
    assign null_tail = &null_hist[RUN-1:0];
    assign evt_hi    = (&hi_hist[WIN-1:RUN]) & null_tail;
    assign evt_lo    = (&lo_hist[WIN-1:RUN]) & null_tail;
    assign gap_full  = &null_hist;

endmodule

// File: rtl/trilevel_fsm.sv
module trilevel_fsm #(
    parameter int SP_MIN = 8,
    parameter int SP_MAX = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic samp_d,
    input  logic bad_q,
    input  logic evt_hi,
    input  logic evt_lo,
    input  logic gap_full,
    output logic bit_valid,
    output logic bit_value,
    output logic err
);
    import trilevel_pkg::*;

    localparam int CNT_W = $clog2(SP_MAX + 2);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;
    localparam logic [CNT_W:0]   LIM_LO  = SP_MIN[CNT_W:0];
    localparam logic [CNT_W:0]   LIM_HI  = SP_MAX[CNT_W:0];

    vld_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W:0]   spacing;
    logic             evt, accept;

    assign evt     = evt_hi | evt_lo;
    assign spacing = {1'b0, cnt_q} + 1'b1;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        accept  = 1'b0;
        if (samp_d) begin
            if (cnt_q != CNT_TOP) cnt_d = cnt_q + 1'b1;
            if (bad_q) begin
                state_d = S_ABORT;
            end else begin
                unique case (state_q)
                    S_IDLE: begin
                        if (evt) begin
                            state_d = S_WORD;
                            accept  = 1'b1;
                            cnt_d   = '0;
                        end
                    end
                    S_WORD: begin
                        if (evt) begin
                            if (spacing >= LIM_LO && spacing <= LIM_HI) begin
                                accept = 1'b1;
                                cnt_d  = '0;
                            end else begin
                                state_d = S_ABORT;
                            end
                        end else if (gap_full && spacing > LIM_HI) begin
                            state_d = S_IDLE;
                        end
                    end
                    S_ABORT: begin
                        if (gap_full) state_d = S_IDLE;
                    end
                    default: state_d = S_IDLE;
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_valid <= 1'b0;
            bit_value <= 1'b0;
            err       <= 1'b0;
        end else begin
            bit_valid <= accept;
            if (accept) bit_value <= evt_hi;
            err       <= (state_d == S_ABORT);
        end
    end

    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |=> !bit_valid);

    assert_value_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |-> $stable(bit_value));

    assert_no_strobe_in_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !bit_valid);

endmodule

// File: rtl/trilevel_validator.sv
module trilevel_validator #(
    parameter int HIST_LEN = 10,
    parameter int RUN      = 3,
    parameter int SP_MIN   = 8,
    parameter int SP_MAX   = 12,
    parameter int DIV_LOW  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic speed_low,
    input  logic one_det,
    input  logic zero_det,
    output logic bit_valid,
    output logic bit_value,
    output logic err
);
    logic                samp_en, samp_d, bad_q;
    logic [HIST_LEN-1:0] hi_hist, lo_hist, null_hist;
    logic                evt_hi, evt_lo, gap_full;

    trilevel_sampler #(.HIST_LEN(HIST_LEN), .DIV_LOW(DIV_LOW)) u_sampler (
        .clk(clk), .rst_n(rst_n), .speed_low(speed_low),
        .one_det(one_det), .zero_det(zero_det),
        .samp_en(samp_en), .samp_d(samp_d), .bad_q(bad_q),
        .hi_hist(hi_hist), .lo_hist(lo_hist), .null_hist(null_hist)
    );

    trilevel_shape #(.HIST_LEN(HIST_LEN), .RUN(RUN)) u_shape (
        .hi_hist(hi_hist), .lo_hist(lo_hist), .null_hist(null_hist),
        .evt_hi(evt_hi), .evt_lo(evt_lo), .gap_full(gap_full)
    );

    trilevel_fsm #(.SP_MIN(SP_MIN), .SP_MAX(SP_MAX)) u_fsm (
        .clk(clk), .rst_n(rst_n), .samp_d(samp_d), .bad_q(bad_q),
        .evt_hi(evt_hi), .evt_lo(evt_lo), .gap_full(gap_full),
        .bit_valid(bit_valid), .bit_value(bit_value), .err(err)
    );

    assert_invalid_sample_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_en && one_det && zero_det) |-> ##2 err);

    assert_swing_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_en && one_det && !zero_det && lo_hist[0]) |-> ##2 err);

endmodule

// File: tb/test_trilevel_validator.sv
module test_trilevel_validator;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic speed_low = 1'b0;
    logic one_det = 1'b0;
    logic zero_det = 1'b0;
    logic bit_valid, bit_value, err;

    int tests_run = 0;
    int tests_failed = 0;
    int sps = 1;
    int got_n = 0;
    logic [31:0] got_bits = '0;

    always #4 clk = ~clk;

    trilevel_validator i_trilevel_validator (
        .clk(clk), .rst_n(rst_n), .speed_low(speed_low),
        .one_det(one_det), .zero_det(zero_det),
        .bit_valid(bit_valid), .bit_value(bit_value), .err(err)
    );

    always @(negedge clk) begin
        if (rst_n && bit_valid) begin
            got_n    <= got_n + 1;
            got_bits <= {got_bits[30:0], bit_value};
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        tests_run++;
        if (act != exp) begin
            tests_failed++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic slow);
        speed_low = slow;
        sps       = slow ? 8 : 1;
        one_det   = 1'b0;
        zero_det  = 1'b0;
        rst_n     = 1'b0;
        repeat (3) @(negedge clk);
        got_n    = 0;
        got_bits = '0;
        rst_n    = 1'b1;
    endtask

    task automatic put(input logic o, input logic z);
        one_det  = o;
        zero_det = z;
        repeat (sps) @(negedge clk);
    endtask

    task automatic pulse(input logic v, input int h, input int l);
        for (int i = 0; i < h; i++) put(v, ~v);
        for (int i = 0; i < l; i++) put(1'b0, 1'b0);
    endtask

    task automatic settle();
        repeat (4 * sps) @(negedge clk);
    endtask

    task automatic t_reset();
        speed_low = 1'b0;
        rst_n = 1'b0;
        one_det = 1'b1;
        zero_det = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 bit_valid in reset", bit_valid, 0);
        chk("R10 bit_value in reset", bit_value, 0);
        chk("R10 err in reset", err, 0);
    endtask

    task automatic t_train();
        do_reset(1'b0);
        pulse(1, 5, 5); pulse(0, 5, 5); pulse(1, 5, 5); pulse(1, 5, 5); pulse(0, 5, 5);
        settle();
        chk("R3 train strobe count", got_n, 5);
        chk("R3 train bit values", int'(got_bits[4:0]), 5'b10110);
        chk("R3 train no error", err, 0);
    endtask

    task automatic t_latency();
        do_reset(1'b0);
        for (int i = 0; i < 5; i++) put(1, 0);
        put(0, 0); put(0, 0); put(0, 0);
        chk("R3 no strobe one clock after third null", bit_valid, 0);
        @(negedge clk);
        chk("R3 strobe two clocks after third null", bit_valid, 1);
        chk("R3 strobe value high", bit_value, 1);
        @(negedge clk);
        chk("R6 strobe single clock", bit_valid, 0);
        repeat (6) @(negedge clk);
        chk("R6 value held after strobe", bit_value, 1);
    endtask

    task automatic t_bounds();
        do_reset(1'b0);
        pulse(0, 5, 3); pulse(1, 5, 7); pulse(0, 5, 5);
        settle();
        chk("R4 spacing 8 and 12 accepted", got_n, 3);
        chk("R4 boundary values", int'(got_bits[2:0]), 3'b010);
        chk("R4 boundary no error", err, 0);
    endtask

    task automatic t_spacing_bad();
        do_reset(1'b0);
        pulse(1, 5, 3); pulse(1, 4, 3);
        settle();
        chk("R4 spacing 7 error", err, 1);
        chk("R4 spacing 7 not strobed", got_n, 1);
        do_reset(1'b0);
        pulse(1, 5, 8); pulse(1, 5, 3);
        settle();
        chk("R4 spacing 13 error", err, 1);
        chk("R4 spacing 13 not strobed", got_n, 1);
    endtask

    task automatic t_abort();
        do_reset(1'b0);
        pulse(1, 5, 8); pulse(1, 5, 5);
        pulse(0, 5, 5); pulse(1, 5, 5); pulse(0, 5, 5);
        chk("R8 bits ignored during error", got_n, 1);
        chk("R8 error held", err, 1);
        for (int i = 0; i < 12; i++) put(0, 0);
        settle();
        chk("R8 error cleared by null gap", err, 0);
        pulse(0, 5, 5);
        settle();
        chk("R8 bit accepted after re-arm", got_n, 2);
        chk("R8 re-armed bit value", int'(got_bits[0]), 0);
    endtask

    task automatic t_wordgap();
        do_reset(1'b0);
        pulse(1, 5, 5); pulse(0, 5, 20); pulse(1, 5, 5);
        settle();
        chk("R9 word end then first bit accepted", got_n, 3);
        chk("R9 no error across word gap", err, 0);
    endtask

    task automatic t_invalid();
        do_reset(1'b0);
        pulse(1, 5, 5);
        put(1, 1);
        one_det = 1'b0; zero_det = 1'b0;
        chk("R5 err not yet one clock after", err, 0);
        @(negedge clk);
        chk("R5 err after invalid sample", err, 1);
    endtask

    task automatic t_swing();
        do_reset(1'b0);
        for (int i = 0; i < 4; i++) put(1, 0);
        put(0, 1);
        one_det = 1'b0; zero_det = 1'b0;
        @(negedge clk);
        chk("R7 err after direct swing", err, 1);
        chk("R7 no strobe", got_n, 0);
    endtask

    task automatic t_short_run();
        do_reset(1'b0);
        pulse(1, 2, 12);
        settle();
        chk("R2 two-sample run rejected", got_n, 0);
        pulse(0, 3, 5);
        settle();
        chk("R2 three-sample run accepted", got_n, 1);
        chk("R2 three-sample run value", int'(got_bits[0]), 0);
    endtask

    task automatic t_shape();
        do_reset(1'b0);
        pulse(1, 5, 2); pulse(1, 5, 5);
        settle();
        chk("R3 pulse lacking three nulls rejected", got_n, 1);
    endtask

    task automatic t_slow();
        do_reset(1'b1);
        pulse(1, 5, 5); pulse(0, 5, 5); pulse(1, 5, 5);
        settle();
        chk("R1 slow train strobe count", got_n, 3);
        chk("R1 slow train values", int'(got_bits[2:0]), 3'b101);
        chk("R1 slow train no error", err, 0);
        do_reset(1'b1);
        sps = 1;
        pulse(1, 5, 40);
        sps = 8;
        settle();
        chk("R1 5-clock level ignored in slow mode", got_n, 0);
        chk("R1 5-clock level no error in slow mode", err, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests_run++;
        tests_failed++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_train();
        t_latency();
        t_bounds();
        t_spacing_bad();
        t_abort();
        t_wordgap();
        t_invalid();
        t_swing();
        t_short_run();
        t_shape();
        t_slow();
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule